// File: doc/BRIEF.md
# Stuffed Frame Synchronizer and Tributary Destuffer

This block takes one serial bit per clock from a higher-rate multiplexed line. It finds the frame structure, then splits the stream into separate tributary bit streams and removes the bits that the transmitter stuffed in. Each subframe holds six control slots, and 48 information bits (`INFO_BITS`) follow each control slot. The control slots of a subframe come in this order: M, C, F0, C, C, F1. Information bits are interleaved bit by bit across the tributaries. There is one subframe per tributary. The four M bits of a multiframe read 0, 1, 1, 1, and the subframe that carries the 0 is subframe 0.

Framing works in two steps. First the block looks for the alternating framing bits F0 and F1, testing one candidate bit phase at a time. It then confirms that phase with the M sequence before it declares alignment. While aligned, the block collects the three C bits of each subframe and takes a majority vote on them. When the vote calls for a stuff, the block drops the stuffed bit instead of writing it to its tributary. Each output is one data bit and one write strobe per tributary, plus an in-frame level and a one-cycle reframe pulse. These outputs feed per-tributary receive stores, which lie outside this block.

Top module: `stuff_frame_demux`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `in_frame`, `reframe` and every `trib_we` bit are 0.
- R2: In a well-formed stream, F0 (bit 0) sits at control slot 2 and F1 (bit 1) at control slot 5 of every subframe. The block declares `in_frame` only after two events, in order: four consecutive correct F bits at one candidate phase, then an M sequence 0, 1, 1, 1 on control slot 0 of successive subframes.
- R3: If the F bits are correct but the M bits never form 0, 1, 1, 1 (for example, all M bits are 1), `in_frame` never rises.
- R4: While `in_frame` is high, information bit i (0-based) of each 48-bit block goes to tributary i mod 4. The bit appears on `trib_data[i mod 4]`, with that `trib_we` bit high, one clock after it entered on `rx_bit`. No two `trib_we` bits are ever high together.
- R5: If at least two of the three C bits (control slots 1, 3 and 4) of subframe k are 1, then information bit k of the block that follows F1 (control slot 5) in that subframe is not written. Tributary k therefore receives one bit fewer in that multiframe.
- R6: One flipped C bit in a subframe does not change the stuff decision: 0,1,1 still means stuff, and 1,0,0 still means no stuff.
- R7: While `in_frame` is low, no `trib_we` bit is asserted on the next cycle.
- R8: While in frame, two F errors within any eight F bits leave `in_frame` high. A third error within eight F bits drops `in_frame` and raises `reframe` for exactly one cycle, and framing search starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial multiplexed line bit, one per clock |
| trib_data | output | NUM_TRIB | Demultiplexed data bit per tributary |
| trib_we | output | NUM_TRIB | Write strobe per tributary, high when `trib_data` holds a real information bit |
| in_frame | output | 1 | High while alignment is held |
| reframe | output | 1 | One-cycle pulse when alignment is lost |

## Verification
Several properties are checked by assertions on every cycle:
- at most one tributary strobe is high at a time;
- no strobe follows an out-of-frame cycle;
- `reframe` lasts one cycle and coincides with `in_frame` falling.

Only the bench scenarios can show the other behaviours:
- that the correct bits reach the correct tributary;
- that a majority of C bits removes exactly the right slot, and one flipped C bit does not change the decision;
- that a stream which mimics F but lacks the M sequence never locks;
- that two F errors in the window are tolerated while three are not.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } sync_state_t;

  localparam int CTL_W     = 3;
  localparam int CTL_COUNT = 6;

  // Control slot roles inside a subframe; the order is decoded by the far end.
  localparam logic [CTL_W-1:0] CTL_M  = 3'd0;
  localparam logic [CTL_W-1:0] CTL_CA = 3'd1;
  localparam logic [CTL_W-1:0] CTL_F0 = 3'd2;
  localparam logic [CTL_W-1:0] CTL_CB = 3'd3;
  localparam logic [CTL_W-1:0] CTL_CC = 3'd4;
  localparam logic [CTL_W-1:0] CTL_F1 = 3'd5;
  localparam logic [CTL_W-1:0] CTL_LAST = CTL_W'(CTL_COUNT - 1);

endpackage

// File: rtl/sfd_pos_ctr.sv
module sfd_pos_ctr
  import sfd_pkg::*;
#(
  parameter int INFO_BITS = 48,
  parameter int SUBFRAMES = 4,
  parameter int SLOT_W    = $clog2(INFO_BITS + 1),
  parameter int SUB_W     = $clog2(SUBFRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              zero_sub,
  output logic [SLOT_W-1:0] slot,
  output logic [CTL_W-1:0]  ctl,
  output logic [SUB_W-1:0]  sub
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(INFO_BITS);
  localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(SUBFRAMES - 1);

  // hold freezes the position for one bit, slipping the candidate phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      ctl  <= '0;
      sub  <= '0;
    end else if (!hold) begin
      if (slot == SLOT_LAST) begin
        slot <= '0;
        if (ctl == CTL_LAST) begin
          ctl <= '0;
          sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
        end else begin
          ctl <= ctl + 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
      end
      if (zero_sub) sub <= '0;
    end
  end

endmodule

// File: rtl/sfd_frame_fsm.sv
module sfd_frame_fsm
  import sfd_pkg::*;
#(
  parameter int SUBFRAMES = 4,
  parameter int F_LOCK    = 4,
  parameter int LOSS_WIN  = 8,
  parameter int LOSS_THR  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic is_f,
  input  logic f_exp,
  input  logic is_m,
  output logic hold,
  output logic zero_sub,
  output logic in_frame,
  output logic reframe
);

  localparam int FW = $clog2(F_LOCK) + 1;
  localparam int MW = $clog2(SUBFRAMES) + 1;
  localparam logic [FW-1:0] F_LAST = FW'(F_LOCK - 1);
  localparam logic [MW-1:0] M_LAST = MW'(SUBFRAMES - 1);

  sync_state_t         st, st_n;
  logic [FW-1:0]       fcnt, fcnt_n;
  logic [MW-1:0]       mcnt, mcnt_n;
  logic [MW-1:0]       mmiss, mmiss_n;
  logic [LOSS_WIN-1:0] hist, hist_n;
  logic                f_bad, drop;

  always_comb begin
    st_n     = st;
    fcnt_n   = fcnt;
    mcnt_n   = mcnt;
    mmiss_n  = mmiss;
    hist_n   = hist;
    hold     = 1'b0;
    zero_sub = 1'b0;
    drop     = 1'b0;
    f_bad    = is_f && (rx_bit != f_exp);
    unique case (st)
      ST_HUNT: begin
        if (is_f) begin
          if (f_bad) begin
            hold   = 1'b1;
            fcnt_n = '0;
          end else if (fcnt == F_LAST) begin
            st_n    = ST_CONFIRM;
            fcnt_n  = '0;
            mcnt_n  = '0;
            mmiss_n = '0;
          end else begin
            fcnt_n = fcnt + 1'b1;
          end
        end
      end
      ST_CONFIRM: begin
        if (f_bad) begin
          st_n = ST_HUNT;
          hold = 1'b1;
        end else if (is_m) begin
          if (mcnt == '0) begin
            if (!rx_bit) begin
              zero_sub = 1'b1;
              mcnt_n   = MW'(1);
            end else if (mmiss == M_LAST) begin
              st_n = ST_HUNT;
              hold = 1'b1;
            end else begin
              mmiss_n = mmiss + 1'b1;
            end
          end else if (!rx_bit) begin
            st_n = ST_HUNT;
            hold = 1'b1;
          end else if (mcnt == M_LAST) begin
            st_n   = ST_SYNC;
            hist_n = '0;
          end else begin
            mcnt_n = mcnt + 1'b1;
          end
        end
      end
      ST_SYNC: begin
        if (is_f) begin
          hist_n = {hist[LOSS_WIN-2:0], f_bad};
          if ($countones(hist_n) >= LOSS_THR) begin
            st_n   = ST_HUNT;
            drop   = 1'b1;
            hold   = 1'b1;
            fcnt_n = '0;
          end
        end
      end
      default: st_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      fcnt    <= '0;
      mcnt    <= '0;
      mmiss   <= '0;
      hist    <= '0;
      reframe <= 1'b0;
    end else begin
      st      <= st_n;
      fcnt    <= fcnt_n;
      mcnt    <= mcnt_n;
      mmiss   <= mmiss_n;
      hist    <= hist_n;
      reframe <= drop;
    end
  end

  assign in_frame = (st == ST_SYNC);

endmodule

// File: rtl/sfd_stuff_vote.sv
module sfd_stuff_vote
  import sfd_pkg::*;
#(
  parameter int NUM_TRIB = 4,
  parameter int SUB_W    = $clog2(NUM_TRIB)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bit,
  input  logic                ctl_slot,
  input  logic [CTL_W-1:0]    ctl,
  input  logic [SUB_W-1:0]    sub,
  output logic [NUM_TRIB-1:0] stuff_flag
);

  logic [1:0] creg;
  logic       maj;

  // Majority of the two held C bits and the third one arriving now.
  assign maj = (creg[0] & creg[1]) | (creg[0] & rx_bit) | (creg[1] & rx_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      creg       <= '0;
      stuff_flag <= '0;
    end else if (ctl_slot) begin
      case (ctl)
        CTL_M:  stuff_flag <= '0;
        CTL_CA: creg[0] <= rx_bit;
        CTL_CB: creg[1] <= rx_bit;
        CTL_CC: begin
          stuff_flag      <= '0;
          stuff_flag[sub] <= maj;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sfd_trib_demux.sv
module sfd_trib_demux
  import sfd_pkg::*;
#(
  parameter int NUM_TRIB  = 4,
  parameter int INFO_BITS = 48,
  parameter int SLOT_W    = $clog2(INFO_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bit,
  input  logic                in_frame,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [CTL_W-1:0]    ctl,
  input  logic [NUM_TRIB-1:0] stuff_flag,
  output logic [NUM_TRIB-1:0] trib_data,
  output logic [NUM_TRIB-1:0] trib_we
);

  logic              info;
  logic [SLOT_W-1:0] idx, lane;
  logic [NUM_TRIB-1:0] wr_n;

  assign info = (slot != '0);
  assign idx  = slot - 1'b1;
  assign lane = idx % SLOT_W'(NUM_TRIB);

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_lane
    logic skip;
    assign skip    = (ctl == CTL_F1) && stuff_flag[t] && (idx == SLOT_W'(t));
    assign wr_n[t] = in_frame && info && (lane == SLOT_W'(t)) && !skip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trib_we   <= '0;
      trib_data <= '0;
    end else begin
      trib_we <= wr_n;
      for (int t = 0; t < NUM_TRIB; t++) begin
        if (wr_n[t]) trib_data[t] <= rx_bit;
      end
    end
  end

endmodule

// File: rtl/stuff_frame_demux.sv
module stuff_frame_demux
  import sfd_pkg::*;
#(
  parameter int NUM_TRIB  = 4,
  parameter int INFO_BITS = 48,
  parameter int F_LOCK    = 4,
  parameter int LOSS_WIN  = 8,
  parameter int LOSS_THR  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bit,
  output logic [NUM_TRIB-1:0] trib_data,
  output logic [NUM_TRIB-1:0] trib_we,
  output logic                in_frame,
  output logic                reframe
);

  localparam int SUBFRAMES = NUM_TRIB;
  localparam int SLOT_W    = $clog2(INFO_BITS + 1);
  localparam int SUB_W     = $clog2(SUBFRAMES);

  logic [SLOT_W-1:0]   slot;
  logic [CTL_W-1:0]    ctl;
  logic [SUB_W-1:0]    sub;
  logic                ctl_slot, is_f, f_exp, is_m;
  logic                hold, zero_sub;
  logic [NUM_TRIB-1:0] stuff_flag;

  assign ctl_slot = (slot == '0);
  assign is_f     = ctl_slot && ((ctl == CTL_F0) || (ctl == CTL_F1));
  assign f_exp    = (ctl == CTL_F1);
  assign is_m     = ctl_slot && (ctl == CTL_M);

  sfd_pos_ctr #(
    .INFO_BITS(INFO_BITS), .SUBFRAMES(SUBFRAMES), .SLOT_W(SLOT_W), .SUB_W(SUB_W)
  ) pos_i (
    .clk(clk), .rst(rst), .hold(hold), .zero_sub(zero_sub),
    .slot(slot), .ctl(ctl), .sub(sub)
  );

  sfd_frame_fsm #(
    .SUBFRAMES(SUBFRAMES), .F_LOCK(F_LOCK), .LOSS_WIN(LOSS_WIN), .LOSS_THR(LOSS_THR)
  ) fsm_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .is_f(is_f), .f_exp(f_exp), .is_m(is_m),
    .hold(hold), .zero_sub(zero_sub), .in_frame(in_frame), .reframe(reframe)
  );

  sfd_stuff_vote #(
    .NUM_TRIB(NUM_TRIB), .SUB_W(SUB_W)
  ) vote_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .ctl_slot(ctl_slot), .ctl(ctl),
    .sub(sub), .stuff_flag(stuff_flag)
  );

  sfd_trib_demux #(
    .NUM_TRIB(NUM_TRIB), .INFO_BITS(INFO_BITS), .SLOT_W(SLOT_W)
  ) demux_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .in_frame(in_frame), .slot(slot),
    .ctl(ctl), .stuff_flag(stuff_flag), .trib_data(trib_data), .trib_we(trib_we)
  );

endmodule

// File: rtl/sfd_checker.sv
module sfd_checker #(
  parameter int NUM_TRIB = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_TRIB-1:0] trib_we,
  input logic                in_frame,
  input logic                reframe
);

  // R7
  no_wr_unframed_chk: assert property (@(posedge clk) disable iff (rst)
    !in_frame |=> (trib_we == '0));

  // R4
  single_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trib_we));

  // R8
  reframe_width_chk: assert property (@(posedge clk) disable iff (rst)
    reframe |=> !reframe);

  // R8
  reframe_loss_chk: assert property (@(posedge clk) disable iff (rst)
    reframe |-> (!in_frame && $past(in_frame)));

  // R8
  loss_signalled_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_frame) |-> reframe);

endmodule

bind stuff_frame_demux sfd_checker #(.NUM_TRIB(NUM_TRIB)) chk_i (
  .clk(clk), .rst(rst), .trib_we(trib_we), .in_frame(in_frame), .reframe(reframe)
);

// File: tb/stuff_frame_demux_tb_top.sv
module stuff_frame_demux_tb_top;

  localparam int NT     = 4;
  localparam int IB     = 12;
  localparam int BLK    = IB + 1;
  localparam int SUBLEN = 6 * BLK;
  localparam int MFLEN  = NT * SUBLEN;
  localparam int PER_MF = (6 * IB) / NT * NT / NT * 1;  // bits per tributary per subframe-set
  localparam int LANE_MF = NT * 6 * IB / NT;             // bits per tributary per multiframe

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_bit = 1'b0;
  logic [NT-1:0] trib_data, trib_we;
  logic          in_frame, reframe;

  always #2.5 clk = ~clk;

  stuff_frame_demux #(.NUM_TRIB(NT), .INFO_BITS(IB)) dut_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .trib_data(trib_data),
    .trib_we(trib_we), .in_frame(in_frame), .reframe(reframe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int p = 37;
  logic [NT-1:0] stuff_mask = '0;
  logic [NT-1:0] c_err_mask = '0;
  bit m_bad = 1'b0;
  logic [7:0] f_flip = '0;
  int f_idx = 8;
  logic [15:0] lfsr = 16'hACE1;

  int prev_kind = 0;  // 0 control, 1 real info, 2 stuffed slot
  int prev_trib = 0;
  logic prev_val = 1'b0;
  logic prev_inf = 1'b0;

  int wr_cnt [NT];
  int bad_wr, miss_wr, rf_cnt;
  bit rf_wide, rf_fell_ok, saw_inf, rf_last;

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int t = 0; t < NT; t++) wr_cnt[t] = 0;
    bad_wr = 0; miss_wr = 0; rf_cnt = 0;
    rf_wide = 1'b0; rf_fell_ok = 1'b1; saw_inf = 1'b0;
  endtask

  // One line bit: observe the result of the previous bit, then drive the next.
  task automatic step();
    int sb, r, c, s;
    logic b;
    int kind, tr;
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      if (trib_we[t]) begin
        wr_cnt[t]++;
        if (!(prev_kind == 1 && prev_trib == t && trib_data[t] == prev_val)) bad_wr++;
      end else if (prev_kind == 1 && prev_trib == t && prev_inf) begin
        miss_wr++;
      end
    end
    if (reframe) begin
      rf_cnt++;
      if (rf_last) rf_wide = 1'b1;
      if (in_frame) rf_fell_ok = 1'b0;
    end
    rf_last = reframe;
    if (in_frame) saw_inf = 1'b1;

    sb = p / SUBLEN; r = p % SUBLEN; c = r / BLK; s = r % BLK;
    kind = 0; tr = 0; b = 1'b0;
    if (s == 0) begin
      case (c)
        0: b = m_bad ? 1'b1 : (sb != 0);
        1: b = stuff_mask[sb] ^ c_err_mask[sb];
        3, 4: b = stuff_mask[sb];
        default: begin
          b = (c == 5);
          if (f_idx < 8) begin
            b = b ^ f_flip[f_idx];
            f_idx++;
          end
        end
      endcase
    end else begin
      tr = (s - 1) % NT;
      if (c == 5 && stuff_mask[sb] && (s - 1) == sb) begin
        kind = 2; b = 1'b1;
      end else begin
        kind = 1; b = lfsr[0];
        lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      end
    end
    rx_bit = b;
    prev_kind = kind; prev_trib = tr; prev_val = b; prev_inf = in_frame;
    p = (p + 1) % MFLEN;
  endtask

  task automatic run_mframes(int n);
    repeat (n) begin
      step();
      while (p != 0) step();
    end
  endtask

  task automatic wait_lock(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40000 && !ok; i++) begin
      step();
      if (in_frame) ok = 1'b1;
    end
    run_mframes(1);
  endtask

  task automatic t_reset();
    check(in_frame == 1'b0, "R1", "in_frame after reset", int'(in_frame), 0);
    check(reframe == 1'b0, "R1", "reframe after reset", int'(reframe), 0);
    check(trib_we == '0, "R1", "trib_we after reset", int'(trib_we), 0);
  endtask

  task automatic t_mimic();
    int tot;
    m_bad = 1'b1;
    clear_counts();
    run_mframes(30);
    tot = wr_cnt[0] + wr_cnt[1] + wr_cnt[2] + wr_cnt[3];
    check(!saw_inf, "R3", "in_frame seen with broken M sequence", int'(saw_inf), 0);
    check(tot == 0, "R7", "writes while out of frame", tot, 0);
    m_bad = 1'b0;
  endtask

  task automatic t_lock();
    bit ok;
    wait_lock(ok);
    check(ok && in_frame, "R2", "alignment acquired", int'(in_frame), 1);
  endtask

  task automatic t_plain();
    stuff_mask = '0; c_err_mask = '0;
    clear_counts();
    run_mframes(3);
    for (int t = 0; t < NT; t++)
      check(wr_cnt[t] == 3 * LANE_MF, "R4", $sformatf("lane %0d write count", t), wr_cnt[t], 3 * LANE_MF);
    check(bad_wr == 0 && miss_wr == 0, "R4", "wrong or missing writes", bad_wr + miss_wr, 0);
  endtask

  task automatic t_stuff_all();
    stuff_mask = '1; c_err_mask = '0;
    clear_counts();
    run_mframes(2);
    for (int t = 0; t < NT; t++)
      check(wr_cnt[t] == 2 * (LANE_MF - 1), "R5", $sformatf("lane %0d count with stuff", t), wr_cnt[t], 2 * (LANE_MF - 1));
    check(bad_wr == 0 && miss_wr == 0, "R5", "stuffed slot written or bit lost", bad_wr + miss_wr, 0);
  endtask

  task automatic t_stuff_vote_err();
    int exp;
    stuff_mask = 4'b0101; c_err_mask = 4'b1111;
    clear_counts();
    run_mframes(2);
    for (int t = 0; t < NT; t++) begin
      exp = stuff_mask[t] ? 2 * (LANE_MF - 1) : 2 * LANE_MF;
      check(wr_cnt[t] == exp, "R6", $sformatf("lane %0d count with one C error", t), wr_cnt[t], exp);
    end
    check(bad_wr == 0 && miss_wr == 0, "R6", "vote error on data path", bad_wr + miss_wr, 0);
    stuff_mask = '0; c_err_mask = '0;
  endtask

  task automatic t_loss();
    f_flip = 8'b0001_0001; f_idx = 0;
    clear_counts();
    run_mframes(2);
    check(in_frame == 1'b1 && rf_cnt == 0, "R8", "two F errors tolerated", rf_cnt, 0);
    check(bad_wr == 0 && miss_wr == 0, "R8", "data during F errors", bad_wr + miss_wr, 0);
    f_flip = 8'b0001_0101; f_idx = 0;
    clear_counts();
    run_mframes(1);
    check(rf_cnt == 1, "R8", "reframe pulses on third error", rf_cnt, 1);
    check(!rf_wide && rf_fell_ok, "R8", "reframe single cycle with in_frame low", int'(rf_wide), 0);
    f_flip = '0; f_idx = 8;
  endtask

  task automatic t_relock();
    bit ok;
    wait_lock(ok);
    check(ok && in_frame, "R2", "realignment after loss", int'(in_frame), 1);
    clear_counts();
    run_mframes(1);
    check(wr_cnt[0] + wr_cnt[1] + wr_cnt[2] + wr_cnt[3] == NT * LANE_MF, "R4",
          "total writes after relock", wr_cnt[0] + wr_cnt[1] + wr_cnt[2] + wr_cnt[3], NT * LANE_MF);
    check(bad_wr == 0 && miss_wr == 0, "R4", "data after relock", bad_wr + miss_wr, 0);
  endtask

  initial begin
    clear_counts();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mimic();
    t_lock();
    t_plain();
    t_stuff_all();
    t_stuff_vote_err();
    t_loss();
    t_relock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL WDOG run not finished actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule